// File: doc/BRIEF.md
# Slotted Host-to-Memory Access Port

This block lets a host processor reach a word-wide external memory that a cell-processing pipeline otherwise owns. The host uses two registers. The first is a control register that holds an address, a direction bit, a size bit and a lane-order bit. The second is a 32-bit data register. Writing the control register queues exactly one access and raises a busy flag. The host polls that flag and must see it clear before it loads either register again.

The queued access does not start at once. It waits for a cycle that the pipeline marks with `slot_strobe`. Such a cycle comes at least once per cell period, and it only counts when `maint` is low. A write transfers either the whole data register or one 16-bit half, using byte-lane enables. A read brings the full memory word back into the data register. Busy clears when the write strobe has been issued, or when the read data has been captured.

Top module: `ind_mem_ctrl`

## Requirements
- R1: After reset, busy is 0, every register field reads 0, and `mem_we` and `mem_re` are low.
- R2: A host write to the control register (`host_reg`=0) while busy is 0 loads the fields and sets busy. The readback layout is: bit 31 busy, bit 30 direction (1 = read), bit 29 size (1 = half word), bit 28 lane order, and the address in the low `ADDR_W` bits.
- R3: A queued access drives `mem_we` or `mem_re` high for exactly one cycle. That cycle is the first one at or after the request in which `slot_strobe` is 1 and `maint` is 0. The strobe carries the stored address on `mem_addr`.
- R4: While `maint` is 1, no strobe is issued and a pending request keeps busy set.
- R5: A full-word write (size 0) drives `mem_be`=4'b1111 with `mem_wdata` equal to the data register. Busy clears on the clock edge that ends the strobe cycle.
- R6: A half-word write enables the upper lanes (`mem_be`=4'b1100) when address bit 0 equals the order bit, and the lower lanes (`mem_be`=4'b0011) when they differ. The data stays in its own lane position.
- R7: A read drives `mem_re` with `mem_be`=4'b1111. The word on `mem_rdata` one cycle later is stored in the data register, and busy clears on that same edge.
- R8: A control-register write while busy is 1 changes no field.
- R9: A data-register write (`host_reg`=1) while busy is 1 is ignored, so the access in progress uses the original data.
- R10: `mem_we` and `mem_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host register access select |
| host_we | input | 1 | Host write enable |
| host_reg | input | 1 | 0 = control register, 1 = data register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of the register selected by `host_reg` |
| slot_strobe | input | 1 | Marks the reserved memory cycle of a cell period |
| maint | input | 1 | Maintenance active; blocks the slot |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte-lane enables |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_re` |

## Verification
The block holds only a few bits of state: busy, a read-wait phase, the control fields and the data register. Every one of them is visible at the ports within one or two cycles. A busy flag stuck high or cleared early shows in the next control readback. A wrong phase shows as a strobe outside a clear slot, a missing strobe, or a doubled strobe in the very slot cycle it affects. A corrupted field or lane choice shows on `mem_addr` and `mem_be` in that slot cycle, and as a wrong word in memory or in the data register one cycle later.

// File: rtl/ind_mem_ctrl.sv
module ind_mem_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic              host_reg,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              slot_strobe,
  input  logic              maint,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [31:0]       mem_rdata
);

  localparam int BUSY_B  = 31;
  localparam int DIR_B   = 30;
  localparam int SIZE_B  = 29;
  localparam int ORDER_B = 28;

  logic              busy, rd_wait;
  logic              dir_q, size_q, order_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic [31:0]       ctrl_view;

  wire ctrl_wr = host_sel & host_we & ~host_reg;
  wire data_wr = host_sel & host_we &  host_reg;
  wire issue   = busy & ~rd_wait & slot_strobe & ~maint;
  wire half_hi = ~(addr_q[0] ^ order_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_wait <= 1'b0;
      dir_q   <= 1'b0;
      size_q  <= 1'b0;
      order_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (rd_wait) begin
        data_q  <= mem_rdata;
        rd_wait <= 1'b0;
        busy    <= 1'b0;
      end else if (issue) begin
        if (dir_q) rd_wait <= 1'b1;
        else       busy    <= 1'b0;
      end
      if (ctrl_wr && !busy) begin
        busy    <= 1'b1;
        dir_q   <= host_wdata[DIR_B];
        size_q  <= host_wdata[SIZE_B];
        order_q <= host_wdata[ORDER_B];
        addr_q  <= host_wdata[ADDR_W-1:0];
      end
      if (data_wr && !busy) data_q <= host_wdata;
    end
  end

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[ADDR_W-1:0]  = addr_q;
    ctrl_view[BUSY_B]      = busy;
    ctrl_view[DIR_B]       = dir_q;
    ctrl_view[SIZE_B]      = size_q;
    ctrl_view[ORDER_B]     = order_q;
  end

  assign host_rdata = host_reg ? data_q : ctrl_view;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;
  assign mem_we     = issue & ~dir_q;
  assign mem_re     = issue &  dir_q;
  assign mem_be     = (dir_q | ~size_q) ? 4'b1111 : (half_hi ? 4'b1100 : 4'b0011);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R3
  slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (slot_strobe && !maint));

  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> !(mem_we || mem_re));

  // R4
  maint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && maint && !rd_wait) |=> busy);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy) |=> busy);

  // R8
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> ($stable(addr_q) && $stable(dir_q) && $stable(size_q) && $stable(order_q)));

  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mem_we) || $past(rd_wait)));

  // R6
  half_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && size_q) |-> ($countones(mem_be) == 2));

endmodule

// File: tb/test_ind_mem_ctrl.sv
module test_ind_mem_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_we = 1'b0, host_reg = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic slot_strobe = 1'b0, maint = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic mem_we, mem_re;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  logic [31:0] mem    [0:255];
  logic [31:0] refmem [0:255];

  bit m_busy = 0, m_dir = 0, m_size = 0, m_order = 0, m_rwait = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [31:0] m_data = '0;
  bit slot_en = 1'b1;

  ind_mem_ctrl #(.ADDR_W(ADDR_W)) i_ind_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slot_strobe(slot_strobe), .maint(maint), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; refmem[i] = '0; end
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(negedge clk) begin
    cyc++;
    slot_strobe <= slot_en && (cyc % 8 == 0);
  end

  always @(posedge clk) begin
    bit busy_old, issue, hi;
    if (!rst_n) begin
      m_busy = 0; m_dir = 0; m_size = 0; m_order = 0; m_rwait = 0;
      m_addr = '0; m_data = '0;
    end else begin
      busy_old = m_busy;
      issue = m_busy && !m_rwait && slot_strobe && !maint;
      if (m_rwait) begin
        m_data = refmem[m_addr[7:0]]; m_rwait = 0; m_busy = 0;
      end else if (issue) begin
        if (m_dir) m_rwait = 1;
        else begin
          hi = (m_addr[0] == m_order);
          if (!m_size) refmem[m_addr[7:0]] = m_data;
          else if (hi) refmem[m_addr[7:0]][31:16] = m_data[31:16];
          else refmem[m_addr[7:0]][15:0] = m_data[15:0];
          m_busy = 0;
        end
      end
      if (host_sel && host_we && !host_reg && !busy_old) begin
        m_busy = 1; m_dir = host_wdata[30]; m_size = host_wdata[29];
        m_order = host_wdata[28]; m_addr = host_wdata[ADDR_W-1:0];
      end
      if (host_sel && host_we && host_reg && !busy_old) m_data = host_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit e_we, e_re;
    logic [31:0] view;
    #(CLK_P/4);
    if (rst_n) begin
      e_we = m_busy && !m_rwait && slot_strobe && !maint && !m_dir;
      e_re = m_busy && !m_rwait && slot_strobe && !maint &&  m_dir;
      chk("R3 we", {31'b0, mem_we}, {31'b0, e_we});
      chk("R3 re", {31'b0, mem_re}, {31'b0, e_re});
      chk("R10 excl", {31'b0, mem_we & mem_re}, 32'b0);
      if (e_we || e_re) begin
        chk("R3 addr", {{(32-ADDR_W){1'b0}}, mem_addr}, {{(32-ADDR_W){1'b0}}, m_addr});
        chk("R6 be", {28'b0, mem_be},
            (e_re || !m_size) ? 32'hF : ((m_addr[0] == m_order) ? 32'hC : 32'h3));
      end
      if (e_we) chk("R5 wdata", mem_wdata, m_data);
      view = '0;
      view[ADDR_W-1:0] = m_addr;
      view[31] = m_busy; view[30] = m_dir; view[29] = m_size; view[28] = m_order;
      chk(host_reg ? "R7 data view" : "R2 ctrl view", host_rdata, host_reg ? m_data : view);
    end
  end

  task automatic host_write(input bit reg_sel, input logic [31:0] val);
    @(negedge clk);
    host_sel = 1; host_we = 1; host_reg = reg_sel; host_wdata = val;
    @(negedge clk);
    host_sel = 0; host_we = 0; host_reg = 0; host_wdata = '0;
  endtask

  task automatic read_reg(input bit reg_sel, output logic [31:0] val);
    @(negedge clk);
    host_reg = reg_sel;
    #(CLK_P/4);
    val = host_rdata;
    #(CLK_P/8);
    host_reg = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    do begin
      read_reg(0, v);
      n++;
    end while (v[31] && n < 200);
    chk({req, " busy clears"}, {31'b0, v[31]}, 32'b0);
  endtask

  function automatic logic [31:0] ctl(bit d, bit s, bit o, int a);
    return {1'b0, d, s, o, 12'b0, 16'(a)};
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_reg(0, v); chk("R1 ctrl reset", v, 32'h0);
    read_reg(1, v); chk("R1 data reset", v, 32'h0);
    chk("R1 no strobes", {30'b0, mem_we, mem_re}, 32'h0);

    host_write(1, 32'hA5A5_1234);
    host_write(0, ctl(0, 0, 0, 3));
    read_reg(0, v); chk("R2 launch readback", v, 32'h8000_0003);
    wait_idle("R5");
    repeat (2) @(negedge clk);
    chk("R5 full write", mem[3], 32'hA5A5_1234);

    host_write(1, 32'h1111_2222);
    host_write(0, ctl(0, 1, 0, 4)); wait_idle("R6");
    host_write(0, ctl(0, 1, 1, 6)); wait_idle("R6");
    host_write(0, ctl(0, 1, 0, 5)); wait_idle("R6");
    host_write(0, ctl(0, 1, 1, 7)); wait_idle("R6");
    repeat (2) @(negedge clk);
    chk("R6 lsb0 ord0 upper", mem[4], 32'h1111_0000);
    chk("R6 lsb0 ord1 lower", mem[6], 32'h0000_2222);
    chk("R6 lsb1 ord0 lower", mem[5], 32'h0000_2222);
    chk("R6 lsb1 ord1 upper", mem[7], 32'h1111_0000);

    host_write(0, ctl(1, 0, 0, 3)); wait_idle("R7");
    read_reg(1, v); chk("R7 read data", v, 32'hA5A5_1234);
    host_write(0, ctl(1, 1, 1, 7)); wait_idle("R7");
    read_reg(1, v); chk("R7 read ignores size", v, 32'h1111_0000);

    host_write(1, 32'hDEAD_BEEF);
    maint = 1;
    host_write(0, ctl(0, 0, 0, 9));
    host_write(0, ctl(1, 1, 1, 10));
    host_write(1, 32'h0BAD_0BAD);
    repeat (30) @(negedge clk);
    read_reg(0, v); chk("R4 still busy", v, 32'h8000_0009);
    chk("R8 ctrl ignored", v & 32'h7FFF_FFFF, 32'h0000_0009);
    read_reg(1, v); chk("R9 data ignored", v, 32'hDEAD_BEEF);
    chk("R4 no write in maint", mem[9], 32'h0);
    maint = 0;
    wait_idle("R4");
    repeat (2) @(negedge clk);
    chk("R9 original data written", mem[9], 32'hDEAD_BEEF);
    chk("R8 no stray write", mem[10], 32'h0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule